// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which interrupt request the processor core should service next, and whether that request may interrupt the handler that is already running. It serves a parameterised set of programmable sources and two fixed system exceptions, a non-maskable interrupt and a hard fault. Each programmable source has an 8-bit priority register, of which only the most significant `PRIO_BITS` bits are kept. A 3-bit group setting divides each kept value into a preemption part and a subpriority part. Only the preemption part decides whether a request may nest on top of the running handler. The subpriority, and after it the source number, only order requests that are pending together.

The arbiter keeps a stack of the preemption levels of the handlers that are active. A take strobe pushes the new level. An end-of-handler pulse pops it and restores the interrupted level. Thread mode sits below every priority. Two mask inputs block the programmable sources, and one of them also blocks the hard fault. The output is a one-cycle registered take strobe, the number of the winning request, and the current execution level.

Top module: `nest_prio_arb`

## Requirements
- R1: After reset, `take` is 0, `take_id` is 0 and `cur_level` is the thread code, which is all ones.
- R2: Only bits [7:8-PRIO_BITS] of each priority register take effect. Lower bits read as zero and change neither the winner nor the level.
- R3: With group value g, bits [7:g+1] form the preemption part and bits [g:0] form the subpriority part. A programmable source's level code is 2 plus the value of bits [7:8-PRIO_BITS] of its preemption part, with the subpriority bits cleared.
- R4: A request is taken only when its level code is strictly smaller than `cur_level`. A request whose level code equals `cur_level` is never taken.
- R5: Among eligible requests the winner has the smallest level code, then the smallest subpriority, then the smallest number. Numbering: 0 is the non-maskable interrupt, 1 is the hard fault, 2+i is programmable source i.
- R6: The non-maskable interrupt has level code 0 and the hard fault has level code 1, both above every programmable source. No mask blocks the non-maskable interrupt.
- R7: `mask_prog` blocks all programmable sources. `mask_fault` blocks all programmable sources and the hard fault.
- R8: When a request is presented before a rising edge and is taken, `take` is 1 for exactly the cycle after that edge. `take_id` and `cur_level` update at the same edge. A request that stays pending is not taken again while its level is current.
- R9: `eoh` returns `cur_level` to the level that was current before the most recent take. In thread mode, `eoh` is ignored.
- R10: In a cycle where `eoh` arrives while a handler is active, nothing is taken. Arbitration resumes in the next cycle against the restored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | N_SRC | Pending lines of the programmable sources |
| prio_regs | input | 8*N_SRC | Priority register of source i at bits [8i+7:8i] |
| grp_sel | input | 3 | Preemption/subpriority split point g |
| mask_prog | input | 1 | Blocks every programmable source |
| mask_fault | input | 1 | Blocks programmable sources and hard fault |
| nmi_req | input | 1 | Non-maskable interrupt request |
| fault_req | input | 1 | Hard fault request |
| eoh | input | 1 | End-of-handler pulse |
| take | output | 1 | One-cycle strobe: a request was accepted |
| take_id | output | $clog2(N_SRC+2) | Number of the accepted request |
| cur_level | output | PRIO_BITS+1 | Current execution level code |

## Verification
On every cycle, the assertions check that each take strictly lowers the execution level, that masked classes are never taken, that no take coincides with an end-of-handler pulse, and that the level stack stays strictly ordered and never overflows. Only the bench's scenarios can show which request wins and with what level for a given set of priority values, group settings and mask states. The same holds for the correct restoration order across several nested levels and for the equal-level refusal with specific register contents.

// File: rtl/nest_prio_pkg.sv
package nest_prio_pkg;

    localparam int SYS_CNT   = 2;
    localparam int ID_NMI    = 0;
    localparam int ID_FAULT  = 1;
    localparam int LVL_NMI   = 0;
    localparam int LVL_FAULT = 1;
    localparam int LVL_BASE  = 2;

    typedef struct packed {
        logic [7:0] pre;
        logic [7:0] sub;
    } prio_split_t;

    // Keep the implemented top bits, then divide at bit g.
    function automatic prio_split_t split_prio(input logic [7:0] raw,
                                               input int          kept_bits,
                                               input logic [2:0]  grp);
        prio_split_t r;
        logic [7:0]  keep_m;
        logic [7:0]  pre_m;
        keep_m = 8'hFF << (8 - kept_bits);
        pre_m  = (grp == 3'd7) ? 8'h00 : (8'hFF << (grp + 3'd1));
        r.pre  = raw & keep_m & pre_m;
        r.sub  = raw & keep_m & ~pre_m;
        return r;
    endfunction

endpackage

// File: rtl/prio_decode.sv
module prio_decode
    import nest_prio_pkg::*;
#(
    parameter int PRIO_BITS = 3,
    parameter int LVL_W     = PRIO_BITS + 1
) (
    input  logic [7:0]       prio_raw,
    input  logic [2:0]       grp_sel,
    output logic [LVL_W-1:0] lvl,
    output logic [7:0]       sub
);
    prio_split_t sp;
    logic [7:0]  pre_val;

    always_comb begin
        sp      = split_prio(prio_raw, PRIO_BITS, grp_sel);
        pre_val = sp.pre >> (8 - PRIO_BITS);
        lvl     = LVL_W'(LVL_BASE) + LVL_W'(pre_val);
        sub     = sp.sub;
    end
endmodule

// File: rtl/prio_select.sv
module prio_select #(
    parameter int NCAND = 10,
    parameter int LVL_W = 4,
    parameter int ID_W  = $clog2(NCAND)
) (
    input  logic [NCAND-1:0]            cand_vld,
    input  logic [NCAND-1:0][LVL_W-1:0] cand_lvl,
    input  logic [NCAND-1:0][7:0]       cand_sub,
    output logic                        win_vld,
    output logic [ID_W-1:0]             win_id,
    output logic [LVL_W-1:0]            win_lvl
);
    logic [7:0] win_sub;

    // Lexicographic minimum of {level, subpriority, number}; ascending scan keeps the lower number on ties.
    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        win_lvl = '1;
        win_sub = '1;
        for (int k = 0; k < NCAND; k++) begin
            if (cand_vld[k]) begin
                if (!win_vld || (cand_lvl[k] < win_lvl) ||
                    ((cand_lvl[k] == win_lvl) && (cand_sub[k] < win_sub))) begin
                    win_vld = 1'b1;
                    win_id  = ID_W'(k);
                    win_lvl = cand_lvl[k];
                    win_sub = cand_sub[k];
                end
            end
        end
    end
endmodule

// File: rtl/level_stack.sv
module level_stack #(
    parameter int DEPTH = 10,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             empty,
    output logic             full
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [SP_W-1:0]             sp;
        logic [LVL_W-1:0]            cur;
        logic [DEPTH-1:0][LVL_W-1:0] slot;
    } stk_t;

    stk_t            stk_d, stk_q;
    logic [SP_W-1:0] sp_m1;

    always_comb begin
        stk_d = stk_q;
        sp_m1 = stk_q.sp - SP_W'(1);
        if (push && (stk_q.sp != SP_W'(DEPTH))) begin
            stk_d.slot[stk_q.sp[IX_W-1:0]] = stk_q.cur;
            stk_d.sp                       = stk_q.sp + SP_W'(1);
            stk_d.cur                      = push_lvl;
        end else if (pop && (stk_q.sp != '0)) begin
            stk_d.sp  = sp_m1;
            stk_d.cur = stk_q.slot[sp_m1[IX_W-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q.sp   <= '0;
            stk_q.cur  <= '1;
            stk_q.slot <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign cur_lvl = stk_q.cur;
    assign empty   = (stk_q.sp == '0);
    assign full    = (stk_q.sp == SP_W'(DEPTH));

    // R4: an interrupted level is always a lower urgency (larger code) than the one above it
    a_r4_stack_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_q.sp != '0) |-> (stk_q.slot[sp_m1[IX_W-1:0]] > stk_q.cur));

    // R9: no push beyond capacity, never push and pop together
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/nest_prio_arb.sv
module nest_prio_arb
    import nest_prio_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int PRIO_BITS = 3,
    parameter int NCAND     = N_SRC + SYS_CNT,
    parameter int ID_W      = $clog2(NCAND),
    parameter int LVL_W     = PRIO_BITS + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_pend,
    input  logic [8*N_SRC-1:0] prio_regs,
    input  logic [2:0]         grp_sel,
    input  logic               mask_prog,
    input  logic               mask_fault,
    input  logic               nmi_req,
    input  logic               fault_req,
    input  logic               eoh,
    output logic               take,
    output logic [ID_W-1:0]    take_id,
    output logic [LVL_W-1:0]   cur_level
);
    typedef struct packed {
        logic            take;
        logic [ID_W-1:0] id;
    } out_t;

    logic [NCAND-1:0]            cand_vld;
    logic [NCAND-1:0][LVL_W-1:0] cand_lvl;
    logic [NCAND-1:0][7:0]       cand_sub;
    logic                        win_vld;
    logic [ID_W-1:0]             win_id;
    logic [LVL_W-1:0]            win_lvl;
    logic                        stk_empty, stk_full;
    logic                        do_pop, do_push;
    out_t                        out_d, out_q;

    // system exceptions: fixed levels, zero subpriority
    assign cand_vld[ID_NMI]   = nmi_req;
    assign cand_lvl[ID_NMI]   = LVL_W'(LVL_NMI);
    assign cand_sub[ID_NMI]   = 8'h00;
    assign cand_vld[ID_FAULT] = fault_req & ~mask_fault;
    assign cand_lvl[ID_FAULT] = LVL_W'(LVL_FAULT);
    assign cand_sub[ID_FAULT] = 8'h00;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        prio_decode #(
            .PRIO_BITS (PRIO_BITS),
            .LVL_W     (LVL_W)
        ) u_dec (
            .prio_raw (prio_regs[8*i +: 8]),
            .grp_sel  (grp_sel),
            .lvl      (cand_lvl[SYS_CNT+i]),
            .sub      (cand_sub[SYS_CNT+i])
        );
        assign cand_vld[SYS_CNT+i] = irq_pend[i] & ~mask_prog & ~mask_fault;
    end

    prio_select #(
        .NCAND (NCAND),
        .LVL_W (LVL_W),
        .ID_W  (ID_W)
    ) u_sel (
        .cand_vld (cand_vld),
        .cand_lvl (cand_lvl),
        .cand_sub (cand_sub),
        .win_vld  (win_vld),
        .win_id   (win_id),
        .win_lvl  (win_lvl)
    );

    always_comb begin
        do_pop    = eoh & ~stk_empty;
        do_push   = win_vld & (win_lvl < cur_level) & ~do_pop & ~stk_full;
        out_d     = out_q;
        out_d.take = do_push;
        if (do_push) begin
            out_d.id = win_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    level_stack #(
        .DEPTH (NCAND),
        .LVL_W (LVL_W)
    ) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .push_lvl (win_lvl),
        .pop      (do_pop),
        .cur_lvl  (cur_level),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    assign take    = out_q.take;
    assign take_id = out_q.id;

    // R4: every accepted request strictly raises urgency
    a_r4_strict_nest: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cur_level < $past(cur_level)));

    // R7: masked classes are never accepted
    a_r7_prog_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (take_id >= ID_W'(SYS_CNT))) |-> (!$past(mask_prog) && !$past(mask_fault)));
    a_r7_fault_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (take_id == ID_W'(ID_FAULT))) |-> !$past(mask_fault));

    // R6: the non-maskable interrupt always lands on level code 0
    a_r6_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (take_id == ID_W'(ID_NMI))) |-> (cur_level == LVL_W'(LVL_NMI)));

    // R10: end-of-handler in an active handler suppresses a take
    a_r10_eoh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (eoh && (cur_level != '1)) |=> !take);
endmodule

// File: tb/nest_prio_arb_bench.sv
`timescale 1ns/1ps
module nest_prio_arb_bench;
    localparam int N    = 4;
    localparam int P    = 3;
    localparam int IDW  = $clog2(N + 2);
    localparam int LW   = P + 1;
    localparam logic [LW-1:0] THREAD = '1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_pend = '0;
    logic [8*N-1:0] prio_regs = '0;
    logic [2:0]     grp_sel = '0;
    logic           mask_prog = 1'b0, mask_fault = 1'b0;
    logic           nmi_req = 1'b0, fault_req = 1'b0, eoh = 1'b0;
    logic           take;
    logic [IDW-1:0] take_id;
    logic [LW-1:0]  cur_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nest_prio_arb #(.N_SRC(N), .PRIO_BITS(P)) u_nest_prio_arb (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .prio_regs(prio_regs),
        .grp_sel(grp_sel), .mask_prog(mask_prog), .mask_fault(mask_fault),
        .nmi_req(nmi_req), .fault_req(fault_req), .eoh(eoh),
        .take(take), .take_id(take_id), .cur_level(cur_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input bit t, input int id, input int lvl, input string req);
        chk(take == t, req, int'(take), int'(t));
        if (t) chk(take_id == IDW'(id), req, int'(take_id), id);
        chk(cur_level == LW'(lvl), req, int'(cur_level), lvl);
    endtask

    // Expected winner from the requirement arithmetic (R2, R3, R5, R6, R7)
    task automatic model(input logic [5:0] pat, input bit mp, input bit mf,
                         input logic [2:0] g, output bit found,
                         output int id, output int lvl);
        int best_sub;
        logic [7:0] keep, prem, raw, pre, sub;
        found = 1'b0; id = 0; lvl = 15; best_sub = 256;
        keep = 8'hFF << (8 - P);
        prem = (g == 3'd7) ? 8'h00 : 8'(8'hFF << (g + 1));
        for (int k = 0; k < N + 2; k++) begin
            int l, s;
            bit v;
            if (k == 0) begin v = pat[0]; l = 0; s = 0; end
            else if (k == 1) begin v = pat[1] && !mf; l = 1; s = 0; end
            else begin
                raw = prio_regs[8*(k-2) +: 8];
                pre = raw & keep & prem;
                sub = raw & keep & ~prem;
                v = pat[k] && !mp && !mf;
                l = 2 + int'(pre >> (8 - P));
                s = int'(sub);
            end
            if (v && (!found || l < lvl || (l == lvl && s < best_sub))) begin
                found = 1'b1; id = k; lvl = l; best_sub = s;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed;
        bit f;
        int eid, elvl;
        seed = 32'h1234_5678;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        expect_out(1'b0, 0, 15, "R1");
        chk(take_id == '0, "R1", int'(take_id), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep from thread mode: groups, two register sets, masks, all request patterns
        for (int g = 0; g < 8; g++) begin
            for (int set = 0; set < 2; set++) begin
                for (int i = 0; i < N; i++) begin
                    seed = seed * 32'd1103515245 + 32'd12345;
                    prio_regs[8*i +: 8] = seed[23:16];
                end
                for (int m = 0; m < 4; m++) begin
                    for (int pat = 0; pat < 64; pat++) begin
                        @(negedge clk);
                        grp_sel    = 3'(g);
                        mask_prog  = m[0];
                        mask_fault = m[1];
                        nmi_req    = pat[0];
                        fault_req  = pat[1];
                        irq_pend   = 4'(pat >> 2);
                        model(6'(pat), m[0], m[1], 3'(g), f, eid, elvl);
                        edge_sample();
                        // R5 R3 R2 R6 R7: winner and level
                        expect_out(f, eid, f ? elvl : 15, "R5");
                        edge_sample();
                        // R8: held request not taken again
                        expect_out(1'b0, 0, f ? elvl : 15, "R8");
                        @(negedge clk);
                        nmi_req = 1'b0; fault_req = 1'b0; irq_pend = '0; eoh = 1'b1;
                        edge_sample();
                        // R9: return to thread (or ignored in thread)
                        expect_out(1'b0, 0, 15, "R9");
                        @(negedge clk);
                        eoh = 1'b0;
                    end
                end
            end
        end

        // Directed nesting, g=5: src0=E0 lvl8, src1=40 lvl4, src2=60 lvl4, src3=00 lvl2
        @(negedge clk);
        mask_prog = 1'b0; mask_fault = 1'b0; grp_sel = 3'd5;
        prio_regs = {8'h00, 8'h60, 8'h40, 8'hE0};
        irq_pend = 4'b0001;
        edge_sample(); expect_out(1'b1, 2, 8, "R3");
        @(negedge clk); irq_pend = 4'b0011;
        edge_sample(); expect_out(1'b1, 3, 4, "R4");
        @(negedge clk); irq_pend = 4'b0111;
        edge_sample(); expect_out(1'b0, 0, 4, "R4");
        @(negedge clk); irq_pend = 4'b0101; eoh = 1'b1;
        edge_sample(); expect_out(1'b0, 0, 8, "R9");
        @(negedge clk); eoh = 1'b0;
        edge_sample(); expect_out(1'b1, 4, 4, "R10");
        @(negedge clk); irq_pend = 4'b1101;
        edge_sample(); expect_out(1'b1, 5, 2, "R4");
        @(negedge clk); irq_pend = 4'b0101; fault_req = 1'b1; eoh = 1'b1;
        edge_sample(); expect_out(1'b0, 0, 4, "R10");
        @(negedge clk); eoh = 1'b0;
        edge_sample(); expect_out(1'b1, 1, 1, "R6");
        @(negedge clk); nmi_req = 1'b1; mask_fault = 1'b1; mask_prog = 1'b1;
        edge_sample(); expect_out(1'b1, 0, 0, "R6");
        @(negedge clk); irq_pend = '0; nmi_req = 1'b0; fault_req = 1'b0;
        mask_fault = 1'b0; mask_prog = 1'b0; eoh = 1'b1;
        edge_sample(); expect_out(1'b0, 0, 1, "R9");
        edge_sample(); expect_out(1'b0, 0, 4, "R9");
        edge_sample(); expect_out(1'b0, 0, 8, "R9");
        edge_sample(); expect_out(1'b0, 0, 15, "R9");
        edge_sample(); expect_out(1'b0, 0, 15, "R9");
        @(negedge clk); eoh = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule